// File: doc/BRIEF.md
# Wide Time-Base Counter with Coherent Capture

This block is a free-running 64-bit time-base counter that sits on a plain 32-bit register bus. A prescaler divides the input clock by a programmable ratio, and the counter steps once per prescaler period. The count wraps through the full 64-bit range without ever stopping. Software can read the live count as two 32-bit words. Because the count can move between those two reads, a control command copies the whole count into a pair of capture registers in a single clock. Software then reads the capture pair at leisure, high word first and then low word, and gets a value that does not tear.

A second control command moves a 64-bit preload value, written beforehand as two words, into the counter. This puts the time base back after a restore. The same command restarts the prescaler, so the first step after a load comes one full divided period later.

Reads are combinational from the address. Writes take effect on the rising clock edge when the write strobe is high.

Top module: `tbase64`

## Requirements
- R1: While reset is held, and right after it, the counter, the preload words, the capture words, the divider field and control bit 0 all read as zero.
- R2: With divider field D in control bits [31:16], the counter rises by exactly one on every (D+1)-th clock edge.
- R3: The counter is 64 bits wide. The carry passes from the low word into the high word, and after all ones the counter wraps to zero.
- R4: A control write with bit 1 = 1 and bit 0 = 1 sets the counter to the preload value at that edge and restarts the prescaler phase. N edges after the load edge the count is preload + floor(N/(D+1)).
- R5: A control write with bit 0 = 1 and bit 1 = 0 copies the 64-bit count into the capture pair. The copied value is the count that was present just before that edge.
- R6: The capture pair keeps its value until the next capture command, whatever the counter does in between.
- R7: The control word reads back with the divider in bits [31:16] and the last written bit 0. Bit 1 always reads 0, and all other bits read 0.
- R8: The preload words read back as written. Writes to the live-count and capture addresses change nothing.
- R9: A control write with bit 0 = 0 neither captures nor loads, even when bit 1 is set.
- R10: The register offsets are: control 0x68; live low and high at 0x6C and 0x70; preload low and high at 0x74 and 0x78; capture low and high at 0x7C and 0x80. Any other offset reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter and register clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe, acts on the rising edge |
| reg_addr | input | 8 | Byte offset of the register being accessed |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |

## Verification
The divider sweep covers divide ratios of 1, 2, 3, 4 and 8. Each ratio is combined with four preload values: zero, a value just below a low-word carry, a value just below the 64-bit wrap, and a mixed bit pattern. Together these separate errors in step spacing from errors in carry and wrap. The live count is read on consecutive cycles right after each load, which shows whether the prescaler phase restarts at the load. The capture pair is read at once and again several cycles later, which separates a true one-cycle copy from a register that follows the counter. Control writes with bit 0 clear, and writes aimed at the read-only addresses, show that these leave both the count and the capture pair alone.

// File: rtl/tbase_pkg.sv
package tbase_pkg;
  localparam int BUS_W  = 32;
  localparam int ADDR_W = 8;

  // register offsets (software-visible map)
  localparam logic [ADDR_W-1:0] OFS_CTRL    = 8'h68;
  localparam logic [ADDR_W-1:0] OFS_LIVE_LO = 8'h6C;
  localparam logic [ADDR_W-1:0] OFS_PRE_LO  = 8'h74;
  localparam logic [ADDR_W-1:0] OFS_CAP_LO  = 8'h7C;

  localparam int CTRL_ARM_BIT  = 0;
  localparam int CTRL_LOAD_BIT = 1;
  localparam int CTRL_DIV_LSB  = 16;

  typedef enum logic [1:0] {CMD_NONE, CMD_SNAP, CMD_LOAD} cmd_e;

  // decode of a control write into a command
  function automatic cmd_e ctrl_cmd(input logic [BUS_W-1:0] w);
    if (w[CTRL_ARM_BIT] && w[CTRL_LOAD_BIT]) return CMD_LOAD;
    if (w[CTRL_ARM_BIT])                     return CMD_SNAP;
    return CMD_NONE;
  endfunction

  // byte offset of word idx within a multi-word register
  function automatic logic [ADDR_W-1:0] word_addr(input logic [ADDR_W-1:0] base,
                                                  input int idx);
    return base + ADDR_W'(4 * idx);
  endfunction
endpackage

// File: rtl/tbase_prescaler.sv
module tbase_prescaler #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  input  logic             restart,
  output logic             tick,
  output logic [DIV_W-1:0] phase
);
  // greater-or-equal keeps the period bounded when the divider shrinks
  assign tick = (phase >= div);

  always_ff @(posedge clk) begin
    if (!rst_n)       phase <= '0;
    else if (restart) phase <= '0;
    else if (tick)    phase <= '0;
    else              phase <= phase + 1'b1;
  end
endmodule

// File: rtl/tbase_counter.sv
module tbase_counter #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load_en,
  input  logic [CNT_W-1:0] load_val,
  input  logic             snap_en,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] captured
);
  always_ff @(posedge clk) begin
    if (!rst_n)       count <= '0;
    else if (load_en) count <= load_val;
    else if (tick)    count <= count + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       captured <= '0;
    else if (snap_en) captured <= count;
  end
endmodule

// File: rtl/tbase_regs.sv
module tbase_regs
  import tbase_pkg::*;
#(
  parameter int CNT_W = 64,
  parameter int DIV_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [BUS_W-1:0]  reg_wdata,
  output logic [BUS_W-1:0]  reg_rdata,
  input  logic [CNT_W-1:0]  count,
  input  logic [CNT_W-1:0]  captured,
  output logic [DIV_W-1:0]  div,
  output logic [CNT_W-1:0]  preload,
  output logic              snap_evt,
  output logic              load_evt
);
  localparam int NWORDS = CNT_W / BUS_W;

  logic ctrl_hit;
  logic arm_q;
  cmd_e cmd;

  assign ctrl_hit = reg_wr && (reg_addr == OFS_CTRL);
  assign cmd      = ctrl_cmd(reg_wdata);
  assign snap_evt = ctrl_hit && (cmd == CMD_SNAP);
  assign load_evt = ctrl_hit && (cmd == CMD_LOAD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div   <= '0;
      arm_q <= 1'b0;
    end else if (ctrl_hit) begin
      div   <= reg_wdata[CTRL_DIV_LSB +: DIV_W];
      arm_q <= reg_wdata[CTRL_ARM_BIT];
    end
  end

  // one storage word per bus word of the preload value
  for (genvar gi = 0; gi < NWORDS; gi++) begin : g_pre
    always_ff @(posedge clk) begin
      if (!rst_n)
        preload[gi*BUS_W +: BUS_W] <= '0;
      else if (reg_wr && reg_addr == word_addr(OFS_PRE_LO, gi))
        preload[gi*BUS_W +: BUS_W] <= reg_wdata;
    end
  end

  logic [BUS_W-1:0] ctrl_rd;
  always_comb begin
    ctrl_rd = '0;
    ctrl_rd[CTRL_DIV_LSB +: DIV_W] = div;
    ctrl_rd[CTRL_ARM_BIT]          = arm_q;
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == OFS_CTRL) reg_rdata = ctrl_rd;
    for (int i = 0; i < NWORDS; i++) begin
      if (reg_addr == word_addr(OFS_LIVE_LO, i)) reg_rdata = count[i*BUS_W +: BUS_W];
      if (reg_addr == word_addr(OFS_PRE_LO, i))  reg_rdata = preload[i*BUS_W +: BUS_W];
      if (reg_addr == word_addr(OFS_CAP_LO, i))  reg_rdata = captured[i*BUS_W +: BUS_W];
    end
  end
endmodule

// File: rtl/tbase64.sv
module tbase64
  import tbase_pkg::*;
#(
  parameter int CNT_W = 64,
  parameter int DIV_W = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [7:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata
);
  // named internal events, observed by the bound checker
  logic             tick_w;
  logic             snap_w;
  logic             load_w;
  logic [DIV_W-1:0] div_w;
  logic [DIV_W-1:0] phase_w;
  logic [CNT_W-1:0] count_w;
  logic [CNT_W-1:0] cap_w;
  logic [CNT_W-1:0] pre_w;

  tbase_regs #(.CNT_W(CNT_W), .DIV_W(DIV_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .count(count_w),
    .captured(cap_w), .div(div_w), .preload(pre_w),
    .snap_evt(snap_w), .load_evt(load_w)
  );

  tbase_prescaler #(.DIV_W(DIV_W)) pre_i (
    .clk(clk), .rst_n(rst_n), .div(div_w), .restart(load_w),
    .tick(tick_w), .phase(phase_w)
  );

  tbase_counter #(.CNT_W(CNT_W)) cnt_i (
    .clk(clk), .rst_n(rst_n), .tick(tick_w), .load_en(load_w),
    .load_val(pre_w), .snap_en(snap_w), .count(count_w), .captured(cap_w)
  );
endmodule

// File: rtl/tbase64_chk.sv
module tbase64_chk #(
  parameter int CNT_W = 64,
  parameter int DIV_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             snap,
  input logic             load,
  input logic [DIV_W-1:0] phase,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] captured,
  input logic [CNT_W-1:0] preload
);
  // R2: no step without a prescaler tick
  p_hold_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !tick) |=> count == $past(count));
  // R2, R3: a tick adds one modulo 2^CNT_W
  p_step_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && tick) |=> count == $past(count) + 1'b1);
  // R2: prescaler phase advances by one between ticks
  p_phase_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !tick) |=> phase == $past(phase) + 1'b1);
  // R4: load takes the preload and restarts the phase
  p_load_value_r4: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (count == $past(preload)) && (phase == '0));
  // R5: capture takes the pre-edge count
  p_snap_copy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    snap |=> captured == $past(count));
  // R6: capture pair holds otherwise
  p_cap_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !snap |=> $stable(captured));
  // R9: the two commands never fire together
  p_cmd_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({snap, load}));
endmodule

bind tbase64 tbase64_chk #(.CNT_W(CNT_W), .DIV_W(DIV_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .tick(tick_w), .snap(snap_w), .load(load_w),
  .phase(phase_w), .count(count_w), .captured(cap_w), .preload(pre_w)
);

// File: tb/tbase64_tb_top.sv
module tbase64_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = 8'h00;
  logic [31:0] reg_wdata = '0;
  wire  [31:0] reg_rdata;

  localparam logic [7:0] A_CTRL = 8'h68, A_LLO = 8'h6C, A_LHI = 8'h70,
                         A_PLO = 8'h74, A_PHI = 8'h78, A_CLO = 8'h7C, A_CHI = 8'h80;

  tbase64 dut_i (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
                 .reg_wdata(reg_wdata), .reg_rdata(reg_rdata));

  always #5 clk = ~clk;

  longint unsigned ecount = 0;
  always @(posedge clk) ecount <= ecount + 1;

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, output longint unsigned at);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk);
    #1;
    at = ecount;
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  task automatic rd64(input logic [7:0] lo, output logic [63:0] v, output longint unsigned at);
    logic [31:0] l, h;
    @(negedge clk);
    rd(lo + 8'd4, h);
    rd(lo, l);
    v = {h, l};
    at = ecount;
  endtask

  function automatic logic [63:0] exp_cnt(input logic [63:0] p, input int d,
                                          input longint unsigned l, input longint unsigned e);
    return p + 64'((e - l) / longint'(d + 1));
  endfunction

  initial begin
    #1_000_000;
    n_bad++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] v32;
    logic [63:0] v64, cap_exp;
    longint unsigned t, tl, ts;
    int d_list[5] = '{0, 1, 2, 3, 7};
    logic [63:0] p_list[4] = '{64'h0, 64'h0000_0000_FFFF_FFFD,
                               64'hFFFF_FFFF_FFFF_FFFC, 64'h1234_5678_9ABC_DEF0};

    // R1: reset state
    repeat (3) @(negedge clk);
    rd(A_CTRL, v32); chk("R1 ctrl", 64'(v32), 64'h0);
    rd64(A_LLO, v64, t); chk("R1 live", v64, 64'h0);
    rd64(A_PLO, v64, t); chk("R1 preload", v64, 64'h0);
    rd64(A_CLO, v64, t); chk("R1 capture", v64, 64'h0);
    rst_n = 1'b1;
    // R1: divider zero after reset, so one step per edge
    @(posedge clk); #1; tl = ecount;
    rd64(A_LLO, v64, t); chk("R1 R2 live after reset", v64, 64'(t - tl + 1));

    // R10: unmapped offsets
    @(negedge clk);
    rd(8'h00, v32); chk("R10 unmapped 0x00", 64'(v32), 64'h0);
    rd(8'h84, v32); chk("R10 unmapped 0x84", 64'(v32), 64'h0);
    rd(8'h6A, v32); chk("R10 unmapped 0x6A", 64'(v32), 64'h0);

    foreach (d_list[di]) begin
      foreach (p_list[pi]) begin
        int d = d_list[di];
        logic [63:0] p = p_list[pi];
        // R8: preload readback
        wr(A_PLO, p[31:0], t);
        wr(A_PHI, p[63:32], t);
        rd64(A_PLO, v64, t); chk("R8 preload readback", v64, p);
        // R4: load command
        wr(A_CTRL, {16'(d), 16'h0003}, tl);
        // R7: bit1 reads as zero
        @(negedge clk); rd(A_CTRL, v32);
        chk("R7 ctrl after load", 64'(v32), 64'({16'(d), 16'h0001}));
        // R2 R3 R4: live count on consecutive cycles
        for (int k = 0; k < 10; k++) begin
          rd64(A_LLO, v64, t);
          chk("R2 R3 R4 live count", v64, exp_cnt(p, d, tl, t));
        end
        // R5: capture
        wr(A_CTRL, {16'(d), 16'h0001}, ts);
        cap_exp = exp_cnt(p, d, tl, ts - 1);
        rd64(A_CLO, v64, t); chk("R5 capture value", v64, cap_exp);
        // R6: held while counter moves
        repeat (5) @(negedge clk);
        rd64(A_CLO, v64, t); chk("R6 capture held", v64, cap_exp);
        // R9: bit1 without bit0 does nothing
        wr(A_CTRL, {16'(d), 16'h0002}, t);
        rd64(A_LLO, v64, t); chk("R9 no load", v64, exp_cnt(p, d, tl, t));
        rd64(A_CLO, v64, t); chk("R9 no capture", v64, cap_exp);
        @(negedge clk); rd(A_CTRL, v32);
        chk("R7 ctrl bit0 clear", 64'(v32), 64'({16'(d), 16'h0000}));
        // R8: writes to read-only addresses ignored
        wr(A_LLO, 32'hDEAD_BEEF, t);
        wr(A_CHI, 32'hCAFE_F00D, t);
        rd64(A_LLO, v64, t); chk("R8 live unaffected", v64, exp_cnt(p, d, tl, t));
        rd64(A_CLO, v64, t); chk("R8 capture unaffected", v64, cap_exp);
      end
    end

    // R3: full wrap seen across many steps at divide-by-1
    wr(A_PLO, 32'hFFFF_FFFF, t);
    wr(A_PHI, 32'hFFFF_FFFF, t);
    wr(A_CTRL, 32'h0000_0003, tl);
    repeat (3) @(negedge clk);
    rd64(A_LLO, v64, t); chk("R3 wrap to zero", v64, 64'(t - tl - 1));

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule